// File: doc/BRIEF.md
# Dual-Port GPIO with Flash and Serial-Sensor Sideband Decode

This block is a register-mapped general-purpose I/O unit with two ports, A and D. Each port has an output word, an output-enable word and a read-only input view. The unit sits on a 32-bit bus that accepts whole-word accesses only. The word index is the byte address shifted right by two. Other words in the window hold plain scratch storage.

Some output bits also drive sideband pins. Three bits of the port A output word drive the strobes of a parallel flash device: address latch, command latch and chip enable. The flash busy/ready line appears in the port A input view. On port D, software bit-bangs a serial temperature sensor through two output bits: a clock bit and a data bit. Every write that changes the clock bit raises a one-cycle clock-edge event. The sensor's serial output appears in the port D input view.

A read of an input view returns the port's output word ANDed with its enable word, with the external status bit ORed in. Read data is registered and appears one cycle after the read request.

Top module: `gpio_sideband_unit`

## Requirements
- R1: After reset, every stored word, every pin output, rd_data, rd_valid and sen_clk_edge is zero.
- R2: A valid write stores the full 32-bit data. A later read of that word index returns it unchanged. This holds for any index below NWORDS (23) other than 1 and 17.
- R3: A read of index 1 (port A input view) returns (word 0 AND word 2). Bit 7 of the result is additionally ORed with flash_rdy, sampled in the request cycle.
- R4: A read of index 17 (port D input view) returns (word 16 AND word 18). Bit 4 of the result is additionally ORed with sen_miso, sampled in the request cycle.
- R5: flash_ale, flash_cle and flash_ce follow bits 6, 5 and 4 of word 0 (port A output). They change in the cycle after the write.
- R6: sen_clk follows bit 1 of word 16 (port D output), and sen_mosi follows bit 4 of the same word.
- R7: sen_clk_edge is high for exactly the one cycle after a valid write to index 16 whose bit 1 differs from the stored bit 1. It stays low after any other access.
- R8: An access is valid only when bus_be is 4'hF and bus_addr[1:0] is 0. An invalid write changes no stored word, and an invalid read returns zero.
- R9: Indices NWORDS (23) and above are outside the window. Writes there are dropped, and reads there return zero.
- R10: rd_valid is high for exactly the one cycle after each read request (bus_sel high, bus_wr low). rd_data holds the read word in that cycle.
- R11: pa_out/pa_oe drive words 0 and 2 unchanged, and pd_out/pd_oe drive words 16 and 18 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is valid |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| flash_rdy | input | 1 | Flash ready status |
| flash_ale | output | 1 | Flash address latch strobe |
| flash_cle | output | 1 | Flash command latch strobe |
| flash_ce | output | 1 | Flash chip enable |
| sen_miso | input | 1 | Serial data from the sensor |
| sen_clk | output | 1 | Serial clock level to the sensor |
| sen_mosi | output | 1 | Serial data to the sensor |
| sen_clk_edge | output | 1 | One-cycle clock-edge event |
| pa_out | output | 32 | Port A output word |
| pa_oe | output | 32 | Port A output enables |
| pd_out | output | 32 | Port D output word |
| pd_oe | output | 32 | Port D output enables |

## Verification
A corrupted port A or port D word shows on the pin outputs in the very next cycle, so a per-cycle pin compare catches it at once. A corrupted scratch word stays hidden until the bench reads that index back. For that reason the random stream mixes reads into every index with writes. A wrong previous-clock value shows up as a spurious or missing sen_clk_edge on the first write that follows to index 16. A wrong status merge appears only in reads of index 1 or 17, with the status inputs set to both values.

// File: rtl/gsu_pkg.sv
package gsu_pkg;
  localparam int WORD_W = 32;

  // Word indices; software depends on these positions
  localparam int IX_PA_OUT = 0;
  localparam int IX_PA_IN  = 1;
  localparam int IX_PA_OE  = 2;
  localparam int IX_PD_OUT = 16;
  localparam int IX_PD_IN  = 17;
  localparam int IX_PD_OE  = 18;

  // Sideband bit positions
  localparam int B_ALE   = 6;
  localparam int B_CLE   = 5;
  localparam int B_CE    = 4;
  localparam int B_RDY   = 7;
  localparam int B_SCLK  = 1;
  localparam int B_SMOSI = 4;
  localparam int B_SMISO = 4;

  // Input view: enabled outputs looped back plus one status bit
  function automatic logic [WORD_W-1:0] in_view(
    input logic [WORD_W-1:0] outw,
    input logic [WORD_W-1:0] oew,
    input int unsigned       pos,
    input logic              stat
  );
    logic [WORD_W-1:0] v;
    v = outw & oew;
    v[pos] = v[pos] | stat;
    return v;
  endfunction

  // Clock edge: stored clock bit differs from the one being written
  function automatic logic clk_toggles(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w
  );
    return old_w[B_SCLK] ^ new_w[B_SCLK];
  endfunction
endpackage

// File: rtl/gsu_regfile.sv
module gsu_regfile
  import gsu_pkg::*;
#(
  parameter int NWORDS = 23,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [IDX_W-1:0]  idx,
  input  logic              in_range,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] sel_word,
  output logic [WORD_W-1:0] pa_out_w,
  output logic [WORD_W-1:0] pa_oe_w,
  output logic [WORD_W-1:0] pd_out_w,
  output logic [WORD_W-1:0] pd_oe_w
);
  logic [WORD_W-1:0] words [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_ok && (idx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n)   words[w] <= '0;
      else if (hit) words[w] <= wdata;
    end
  end

  assign sel_word = in_range ? words[idx] : '0;
  assign pa_out_w = words[IX_PA_OUT];
  assign pa_oe_w  = words[IX_PA_OE];
  assign pd_out_w = words[IX_PD_OUT];
  assign pd_oe_w  = words[IX_PD_OE];

  logic wr_pa_q;
  always_ff @(posedge clk) begin
    if (!rst_n) wr_pa_q <= 1'b0;
    else        wr_pa_q <= wr_ok && (idx == IDX_W'(IX_PA_OUT));
  end

  AST_PA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pa_q |-> $stable(pa_out_w)); // R8
endmodule

// File: rtl/gsu_sideband.sv
module gsu_sideband
  import gsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pd,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] pa_out_w,
  input  logic [WORD_W-1:0] pd_out_w,
  output logic              flash_ale,
  output logic              flash_cle,
  output logic              flash_ce,
  output logic              sen_clk,
  output logic              sen_mosi,
  output logic              sen_clk_edge
);
  logic edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= wr_pd && clk_toggles(pd_out_w, wdata);
  end

  assign flash_ale    = pa_out_w[B_ALE];
  assign flash_cle    = pa_out_w[B_CLE];
  assign flash_ce     = pa_out_w[B_CE];
  assign sen_clk      = pd_out_w[B_SCLK];
  assign sen_mosi     = pd_out_w[B_SMOSI];
  assign sen_clk_edge = edge_q;

  AST_EDGE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sen_clk_edge |-> (sen_clk != $past(sen_clk))); // R7
  AST_CHANGE_MEANS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_clk != $past(sen_clk)) |-> sen_clk_edge); // R7
endmodule

// File: rtl/gsu_readmux.sv
module gsu_readmux
  import gsu_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              acc_ok,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] sel_word,
  input  logic [WORD_W-1:0] pa_out_w,
  input  logic [WORD_W-1:0] pa_oe_w,
  input  logic [WORD_W-1:0] pd_out_w,
  input  logic [WORD_W-1:0] pd_oe_w,
  input  logic              flash_rdy,
  input  logic              sen_miso,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [WORD_W-1:0] rd_next;

  always_comb begin
    if (!acc_ok)                          rd_next = '0;
    else if (idx == IDX_W'(IX_PA_IN))     rd_next = in_view(pa_out_w, pa_oe_w, B_RDY, flash_rdy);
    else if (idx == IDX_W'(IX_PD_IN))     rd_next = in_view(pd_out_w, pd_oe_w, B_SMISO, sen_miso);
    else                                  rd_next = sel_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req)); // R10
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !acc_ok) |=> (rd_data == '0)); // R8
endmodule

// File: rtl/gpio_sideband_unit.sv
module gpio_sideband_unit
  import gsu_pkg::*;
#(
  parameter int NWORDS = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  input  logic        flash_rdy,
  output logic        flash_ale,
  output logic        flash_cle,
  output logic        flash_ce,
  input  logic        sen_miso,
  output logic        sen_clk,
  output logic        sen_mosi,
  output logic        sen_clk_edge,
  output logic [31:0] pa_out,
  output logic [31:0] pa_oe,
  output logic [31:0] pd_out,
  output logic [31:0] pd_oe
);
  localparam int IDX_W = 5;

  logic [IDX_W-1:0] idx;
  logic in_range, shape_ok, acc_ok, wr_ok, rd_req, wr_pd;
  logic [WORD_W-1:0] sel_word, pa_out_w, pa_oe_w, pd_out_w, pd_oe_w;

  assign idx      = bus_addr[6:2];
  assign in_range = (int'(idx) < NWORDS);
  assign shape_ok = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign acc_ok   = shape_ok && in_range;
  assign wr_ok    = bus_sel && bus_wr && acc_ok;
  assign rd_req   = bus_sel && !bus_wr;
  assign wr_pd    = wr_ok && (idx == IDX_W'(IX_PD_OUT));

  gsu_regfile #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_regs (
    .clk, .rst_n, .wr_ok, .idx, .in_range, .wdata(bus_wdata),
    .sel_word, .pa_out_w, .pa_oe_w, .pd_out_w, .pd_oe_w
  );

  gsu_sideband u_side (
    .clk, .rst_n, .wr_pd, .wdata(bus_wdata), .pa_out_w, .pd_out_w,
    .flash_ale, .flash_cle, .flash_ce, .sen_clk, .sen_mosi, .sen_clk_edge
  );

  gsu_readmux #(.IDX_W(IDX_W)) u_rd (
    .clk, .rst_n, .rd_req, .acc_ok, .idx, .sel_word,
    .pa_out_w, .pa_oe_w, .pd_out_w, .pd_oe_w,
    .flash_rdy, .sen_miso, .rd_data, .rd_valid
  );

  assign pa_out = pa_out_w;
  assign pa_oe  = pa_oe_w;
  assign pd_out = pd_out_w;
  assign pd_oe  = pd_oe_w;

  AST_STROBES_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    {flash_ale, flash_cle, flash_ce} == {pa_out[B_ALE], pa_out[B_CLE], pa_out[B_CE]}); // R5
  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !in_range) |=> $stable(pd_out) && $stable(pa_out)); // R9
endmodule

// File: tb/gpio_sideband_unit_test.sv
`timescale 1ns/100ps
module gpio_sideband_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [6:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic rd_valid, flash_rdy = 0, flash_ale, flash_cle, flash_ce;
  logic sen_miso = 0, sen_clk, sen_mosi, sen_clk_edge;
  logic [31:0] pa_out, pa_oe, pd_out, pd_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m [0:22];

  always #2.5 clk = ~clk;

  gpio_sideband_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int ix, input bit rdy, input bit miso);
    logic [31:0] v;
    if (ix >= 23) return 32'h0;
    if (ix == 1)  begin v = m[0] & m[2];  if (rdy)  v = v | 32'h80; return v; end
    if (ix == 17) begin v = m[16] & m[18]; if (miso) v = v | 32'h10; return v; end
    return m[ix];
  endfunction

  task automatic check_pins();
    chk("R11 pa_out", pa_out, m[0]);
    chk("R11 pa_oe", pa_oe, m[2]);
    chk("R11 pd_out", pd_out, m[16]);
    chk("R11 pd_oe", pd_oe, m[18]);
    chk("R5 strobes", {29'd0, flash_ale, flash_cle, flash_ce}, {29'd0, m[0][6], m[0][5], m[0][4]});
    chk("R6 sensor pins", {30'd0, sen_clk, sen_mosi}, {30'd0, m[16][1], m[16][4]});
  endtask

  // one bus cycle; inputs set at negedge, outputs checked at next negedge
  task automatic op(input bit wr, input logic [6:0] addr, input logic [3:0] be,
                    input logic [31:0] wd, input bit rdy, input bit miso);
    int ix;
    bit ok, exp_edge;
    logic [31:0] exp_rd;
    ix = int'(addr[6:2]);
    ok = (be == 4'hF) && (addr[1:0] == 2'b00) && (ix < 23);
    exp_rd = ok ? exp_read(ix, rdy, miso) : 32'h0;
    exp_edge = wr && ok && (ix == 16) && (m[16][1] != wd[1]);
    bus_sel = 1; bus_wr = wr; bus_addr = addr; bus_be = be; bus_wdata = wd;
    flash_rdy = rdy; sen_miso = miso;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0;
    if (wr && ok) m[ix] = wd;
    chk("R10 rd_valid", {31'd0, rd_valid}, {31'd0, !wr});
    if (!wr) chk(ok ? "R2/R3/R4 read" : "R8/R9 bad read", rd_data, exp_rd);
    chk("R7 clk edge", {31'd0, sen_clk_edge}, {31'd0, exp_edge});
    check_pins();
  endtask

  initial begin : watchdog
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 23; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'h0);
    chk("R1 edge", {31'd0, sen_clk_edge}, 32'h0);
    check_pins();
    rst_n = 1;
    @(negedge clk);
    op(0, 7'h14, 4'hF, 0, 0, 0);                 // R1 scratch reads zero
    // R5: strobes
    op(1, 7'h00, 4'hF, 32'h70, 0, 0);
    op(1, 7'h00, 4'hF, 32'h20, 0, 0);
    // R3: enable mask and ready merge
    op(1, 7'h08, 4'hF, 32'hFFFF_0F0F, 0, 0);
    op(0, 7'h04, 4'hF, 0, 1, 0);
    op(0, 7'h04, 4'hF, 0, 0, 0);
    // R7/R6: clock toggles, repeat same level
    op(1, 7'h40, 4'hF, 32'h2, 0, 0);
    op(1, 7'h40, 4'hF, 32'h12, 0, 0);            // no edge, mosi up
    op(1, 7'h40, 4'hF, 32'h10, 0, 0);            // falling edge
    // R4: miso merge
    op(1, 7'h48, 4'hF, 32'hFFFF_FFEF, 0, 0);
    op(0, 7'h44, 4'hF, 0, 0, 1);
    op(0, 7'h44, 4'hF, 0, 0, 0);
    // R8: partial byte enables and misaligned address dropped
    op(1, 7'h40, 4'h3, 32'h2, 0, 0);
    op(1, 7'h41, 4'hF, 32'h2, 0, 0);
    op(0, 7'h40, 4'h1, 0, 0, 0);
    // R9: out of window
    op(1, 7'h5C, 4'hF, 32'hDEAD_BEEF, 0, 0);
    op(0, 7'h5C, 4'hF, 0, 0, 0);
    op(0, 7'h7C, 4'hF, 0, 0, 0);
    // R2: scratch word at the window's top
    op(1, 7'h58, 4'hF, 32'hA5A5_5A5A, 0, 0);
    op(0, 7'h58, 4'hF, 0, 0, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] a;
      logic [3:0] be;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: a = 7'h00; 1: a = 7'h04; 2: a = 7'h08;
        3: a = 7'h40; 4: a = 7'h44; 5: a = 7'h48;
        default: a = 7'($urandom_range(0, 127));
      endcase
      if (pick < 6 || $urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      be = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      op($urandom_range(0, 1) == 1, a, be, $urandom, $urandom_range(0, 1) == 1,
         $urandom_range(0, 1) == 1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule